// File: doc/BRIEF.md
# Programmable Counter Delay Generator

The block turns a programmed number into a time delay. Software or a neighbouring block first writes a delay value, counted in clock periods, into a holding register with a load strobe. A later trigger starts a countdown of that value, and when the countdown runs out the block issues a stop pulse one clock wide. The block then enforces a fixed recovery period before it accepts the next trigger.

The countdown is split into two stages. A Johnson ring holds the low-order digit, which has eight states with the default ring of four flops. A synchronous binary register holds the high-order part. The binary part is divided into segments. Each segment keeps a registered zero flag. The flags are chained from the most significant segment down to the least significant one, and the chained result is gated with a two-bit decode of the Johnson state. The stop pulse is registered straight from that gate, so the output edge never waits on a long carry or compare path.

A trigger that arrives while the block is busy has no effect on the running delay. It sets a sticky missed-trigger flag, which only reset clears.

Top module: `pulse_delay_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `pulse_o`, `busy_o` and `missed_o` are all low.
- R2: A trigger sampled at clock edge k while `busy_o` is low gives `pulse_o` high for exactly one cycle, following edge k+D. D is the effective delay taken from the held value.
- R3: The delay is exact across the boundaries of the low digit and the high segments. This includes multiples of the Johnson modulus (8 with defaults) and values that borrow across binary segments, such as 300.
- R4: A held value below `MIN_DLY` (default 3), including 0, is timed as `MIN_DLY`.
- R5: `busy_o` rises after the accepting edge k. It falls after edge k+D+`REARM_CYC` (default 6), so a trigger is accepted again from that point.
- R6: A trigger sampled while `busy_o` is high is ignored. This includes a trigger in the last cycle of the recovery period. The running delay still yields exactly one pulse at k+D, and no new busy period follows.
- R7: A trigger sampled while `busy_o` is high sets `missed_o`. The flag stays high until reset.
- R8: `delay_i` is captured only by `load_i` sampled while `busy_o` is low. A load while busy, or a change on `delay_i` without a load, leaves the delay of later triggers unchanged.
- R9: When `load_i` and `trig_i` are sampled at the same idle edge, the trigger uses the value held before that edge, and the new value serves the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| delay_i | input | DLY_W | Delay value in clock periods |
| load_i | input | 1 | Capture `delay_i` into the holding register when idle |
| trig_i | input | 1 | Start a delay when idle |
| pulse_o | output | 1 | One-cycle stop pulse when the delay ends |
| busy_o | output | 1 | Delay or recovery in progress; triggers are refused |
| missed_o | output | 1 | Sticky: a trigger arrived while busy |

## Verification
Take k as the rising edge that accepts a trigger. The pulse is due after edge k+D, and `busy_o` is due to fall after edge k+D+`REARM_CYC`. A change made by a load or a missed trigger is visible after the edge that samples it. The bench drives and samples on falling edges. It counts falling edges from the first one after edge k, so the count equals the number of rising edges since acceptance. It then compares the count at which the pulse first appears, the number of pulses, and the count at which `busy_o` first reads low against D, 1 and D+`REARM_CYC`.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_REARM = 2'd2
    } pdg_state_e;

    // Johnson code for position idx of a ring of w flops (idx < 2*w).
    function automatic logic [31:0] jc_code(input int unsigned idx, input int unsigned w);
        logic [31:0] r;
        r = '0;
        for (int unsigned b = 0; b < w; b++) begin
            if (idx <= w) r[b] = (b < idx);
            else          r[b] = (b >= idx - w);
        end
        return r;
    endfunction

endpackage

// File: rtl/pdg_johnson.sv
module pdg_johnson #(
    parameter int JW   = 4,
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [LO_W-1:0] load_idx,
    input  logic            step,
    output logic            is_zero,
    output logic            is_one
);
    import pdg_pkg::*;

    logic [JW-1:0] q;
    logic [31:0]   code;

    assign code = jc_code(32'(load_idx), JW);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= code[JW-1:0];
        else if (step) q <= {~q[0], q[JW-1:1]};
    end

    // two-flop decodes, valid for any legal Johnson pattern
    assign is_zero = ~q[0] & ~q[JW-1];
    assign is_one  =  q[0] & ~q[1];

    // R3: the ring never leaves the legal Johnson sequence
    assert_jc_legal_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(q[JW-1:1] ^ q[JW-2:0]) <= 1);

endmodule

// File: rtl/pdg_hicount.sv
module pdg_hicount #(
    parameter int HI_W  = 13,
    parameter int SEG_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [HI_W-1:0] load_val,
    input  logic            dec,
    output logic            all_zero
);
    localparam int NSEG = (HI_W + SEG_W - 1) / SEG_W;
    localparam int PW   = NSEG * SEG_W;

    logic [PW-1:0]   hi_q, hi_nxt;
    logic [NSEG-1:0] seg_zq;
    logic [NSEG:0]   chain;

    always_comb begin
        if (load)     hi_nxt = PW'(load_val);
        else if (dec) hi_nxt = hi_q - PW'(1);
        else          hi_nxt = hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) hi_q <= '0;
        else     hi_q <= hi_nxt;
    end

    assign chain[NSEG] = 1'b1;

    for (genvar i = NSEG - 1; i >= 0; i--) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) seg_zq[i] <= 1'b1;
            else     seg_zq[i] <= (hi_nxt[i*SEG_W +: SEG_W] == '0);
        end
        // zero knowledge travels from the top segment toward the bottom
        assign chain[i] = chain[i+1] & seg_zq[i];
    end

    assign all_zero = chain[0];

    // R3: chained segment flags agree with the whole register
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
        all_zero == (hi_q == '0));
    // R3: the high part is never decremented from zero
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> !all_zero);

endmodule

// File: rtl/pulse_delay_gen.sv
module pulse_delay_gen #(
    parameter int DLY_W     = 16,
    parameter int JW        = 4,   // 2*JW must be a power of two
    parameter int SEG_W     = 4,
    parameter int MIN_DLY   = 3,   // at least 1
    parameter int REARM_CYC = 6    // at least 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             load_i,
    input  logic             trig_i,
    output logic             pulse_o,
    output logic             busy_o,
    output logic             missed_o
);
    import pdg_pkg::*;

    localparam int JMOD = 2 * JW;
    localparam int LO_W = $clog2(JMOD);
    localparam int HI_W = DLY_W - LO_W;
    localparam int RC_W = $clog2(REARM_CYC + 1);

    pdg_state_e       st;
    logic [RC_W-1:0]  rc;
    logic [DLY_W-1:0] dly_q, eff;
    logic             start, counting, fire;
    logic             jc_zero, jc_one, hi_zero;

    assign eff      = (dly_q < DLY_W'(MIN_DLY)) ? DLY_W'(MIN_DLY) : dly_q;
    assign start    = (st == ST_IDLE) && trig_i;
    assign counting = (st == ST_COUNT);
    assign fire     = counting && jc_one && hi_zero;

    pdg_johnson #(.JW(JW), .LO_W(LO_W)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_idx (eff[LO_W-1:0]),
        .step     (counting),
        .is_zero  (jc_zero),
        .is_one   (jc_one)
    );

    pdg_hicount #(.HI_W(HI_W), .SEG_W(SEG_W)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (eff[DLY_W-1:LO_W]),
        .dec      (counting && jc_zero),
        .all_zero (hi_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rc       <= '0;
            pulse_o  <= 1'b0;
            missed_o <= 1'b0;
            dly_q    <= DLY_W'(MIN_DLY);
        end else begin
            pulse_o <= fire;
            if (trig_i && st != ST_IDLE) missed_o <= 1'b1;
            if (load_i && st == ST_IDLE) dly_q <= delay_i;
            unique case (st)
                ST_IDLE:  if (trig_i) st <= ST_COUNT;
                ST_COUNT: if (fire) begin
                    st <= ST_REARM;
                    rc <= RC_W'(REARM_CYC - 1);
                end
                ST_REARM: if (rc == '0) st <= ST_IDLE;
                          else          rc <= rc - RC_W'(1);
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (st != ST_IDLE);

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && trig_i) |=> busy_o);
    assert_pulse_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> busy_o);
    assert_missed_set_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> missed_o);
    assert_missed_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        missed_o |=> missed_o);
    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(dly_q));

endmodule

// File: tb/pulse_delay_gen_tb_top.sv
module pulse_delay_gen_tb_top;

    localparam int MIN_D = 3;
    localparam int RARM  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] delay_i = '0;
    logic        load_i = 1'b0;
    logic        trig_i = 1'b0;
    logic        pulse_o, busy_o, missed_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pulse_delay_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .delay_i  (delay_i),
        .load_i   (load_i),
        .trig_i   (trig_i),
        .pulse_o  (pulse_o),
        .busy_o   (busy_o),
        .missed_o (missed_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_val(input int v);
        @(negedge clk); delay_i = 16'(v); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
    endtask

    // Trigger, then count negedges after the accepting edge (c = rising edges since it).
    task automatic run_one(input bit ld_with_trig, input int ld_v,
                           input int inj_at, input bit inj_trig, input bit inj_load, input int inj_v,
                           output int p_at, output int p_cnt, output int b_low);
        int c = 0;
        p_at = -1; p_cnt = 0; b_low = -1;
        @(negedge clk);
        trig_i = 1'b1;
        if (ld_with_trig) begin delay_i = 16'(ld_v); load_i = 1'b1; end
        @(negedge clk);
        while (b_low < 0 && c < 2000) begin
            trig_i = (c == inj_at) && inj_trig;
            load_i = (c == inj_at) && inj_load;
            if (c == inj_at && inj_load) delay_i = 16'(inj_v);
            if (pulse_o) begin p_cnt++; if (p_at < 0) p_at = c; end
            if (!busy_o && c > 0) b_low = c;
            else begin @(negedge clk); c++; end
        end
        trig_i = 1'b0; load_i = 1'b0;
    endtask

    task automatic t_reset;
        check(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0);
        check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        check(missed_o == 1'b0, "R1 missed", int'(missed_o), 0);
    endtask

    task automatic t_delay(input int v, input int d, input string req);
        int pa, pc, bl;
        load_val(v);
        run_one(1'b0, 0, -1, 1'b0, 1'b0, 0, pa, pc, bl);
        check(pa == d, {req, " pulse time"}, pa, d);
        check(pc == 1, {req, " pulse count"}, pc, 1);
        check(bl == d + RARM, "R5 busy drop", bl, d + RARM);
    endtask

    task automatic t_basic;
        t_delay(20, 20, "R2");
    endtask

    task automatic t_wrap;
        t_delay(8, 8, "R3");
        t_delay(9, 9, "R3");
        t_delay(16, 16, "R3");
        t_delay(300, 300, "R3");
    endtask

    task automatic t_clamp;
        t_delay(0, MIN_D, "R4");
        t_delay(1, MIN_D, "R4");
        t_delay(2, MIN_D, "R4");
        t_delay(3, 3, "R4");
    endtask

    task automatic t_busy_trig;
        int pa, pc, bl;
        load_val(20);
        check(missed_o == 1'b0, "R7 clear before", int'(missed_o), 0);
        run_one(1'b0, 0, 5, 1'b1, 1'b0, 0, pa, pc, bl);
        check(pa == 20, "R6 pulse time", pa, 20);
        check(pc == 1, "R6 pulse count", pc, 1);
        check(missed_o == 1'b1, "R7 set", int'(missed_o), 1);
        repeat (10) @(negedge clk);
        check(missed_o == 1'b1, "R7 sticky", int'(missed_o), 1);
        // trigger on the final recovery cycle
        run_one(1'b0, 0, 20 + RARM - 1, 1'b1, 1'b0, 0, pa, pc, bl);
        @(negedge clk);
        check(busy_o == 1'b0, "R6 late trigger ignored", int'(busy_o), 0);
        check(pulse_o == 1'b0, "R6 no extra pulse", int'(pulse_o), 0);
    endtask

    task automatic t_load_hold;
        int pa, pc, bl;
        load_val(20);
        run_one(1'b0, 0, 4, 1'b0, 1'b1, 50, pa, pc, bl);
        check(pa == 20, "R8 load while busy running", pa, 20);
        run_one(1'b0, 0, -1, 1'b0, 1'b0, 0, pa, pc, bl);
        check(pa == 20, "R8 load while busy ignored", pa, 20);
        @(negedge clk); delay_i = 16'd77;
        run_one(1'b0, 0, -1, 1'b0, 1'b0, 0, pa, pc, bl);
        check(pa == 20, "R8 no load no change", pa, 20);
    endtask

    task automatic t_load_trig;
        int pa, pc, bl;
        load_val(20);
        run_one(1'b1, 33, -1, 1'b0, 1'b0, 0, pa, pc, bl);
        check(pa == 20, "R9 old value used", pa, 20);
        run_one(1'b0, 0, -1, 1'b0, 1'b0, 0, pa, pc, bl);
        check(pa == 33, "R9 new value next", pa, 33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_clamp();
        t_load_hold();
        t_load_trig();
        t_busy_trig();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule